// File: doc/BRIEF.md
# Break Address Comparator with Held NMI Request

This block watches the CPU address bus during ROM accesses. It compares each access against a bank of programmable break addresses. When an enabled entry matches a ROM access, the block raises a non-maskable interrupt request. The request stays asserted until the CPU reads back which entry fired. Software uses it to divert execution at chosen ROM locations without patching the ROM.

Entries are programmed through a 256-byte write window at the top of the 16 MB address space, FFFF00H to FFFFFFH. Each entry takes four bytes at FFFF00H + 4·n:

| Offset | Contents |
|--------|----------|
| 0 | Address bits 19..16, in data bits 3..0 |
| 1 | Address bits 15..8, in data bits 7..0 |
| 2 | Address bits 7..2, in data bits 7..2 |
| 3 | Enable flag, in data bit 7 |

The two upper address bytes are first staged in one temporary register shared by all entries. The complete 18-bit compare value lands in the entry on the write of the lowest address byte. Any read inside the window returns the status byte and acknowledges the request.

Top module: `brk_nmi_unit`

## Requirements
- R1: After reset the request output is low, every entry is disabled, and a status read returns 00H.
- R2: A match compares address bits 19..2 with the entry's stored value. Bits 23..20 and 1..0 of the bus are ignored.
- R3: Writes to offsets 0 and 1 change only the shared temporary register. The entry keeps matching its old value until offset 2 is written, and only then takes {temp bits 3..0, temp byte, data bits 7..2}.
- R4: Offset 3 sets or clears the entry's enable from data bit 7 (1 = enabled), without touching its address. A disabled entry never matches.
- R5: A match needs the ROM select input high in the same cycle as the address.
- R6: A status read returns the latched entry number in data bits 4..0, with bits 7..5 at zero. For example, entry 31 reads 1FH.
- R7: When several enabled entries match in one cycle, the lowest-numbered one is latched.
- R8: The request rises in the cycle after a matching access. It stays high through any number of idle cycles. It falls in the cycle after a status read, which also clears the latched number to zero.
- R9: Every read anywhere in FFFF00H..FFFFFFH acts as the status read. Entry contents can never be read back.
- R10: While a request is pending, further matches leave the latched number unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | CPU address bus |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rom_sel_i | input | 1 | ROM chip select, active high |
| rdata_o | output | 8 | Status byte, driven during a read inside the window, else 00H |
| nmi_o | output | 1 | Held break request |

## Verification
The hardest situation to reach is an entry whose staged upper bytes differ from its committed value. The ports give no view of the temporary register. The stimulus therefore writes offsets 0 and 1 with a new value and then fetches the old address, which must still fire. Next it fetches the new address, which must not fire. Only after that does it write offset 2 and repeat both fetches with the results swapped.

Priority and the pending lock are handled the same way. Two entries are programmed with one value, and one of them is later disabled alone. A third entry is then hit while a request is already pending. The queued status reads show which number was latched each time.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int CMP_W  = 18;   // address bits 19..2
  localparam int SLOT_W = 6;    // addr bits 7..2 inside the window

  typedef enum logic [1:0] {
    OFS_HI  = 2'd0,
    OFS_MID = 2'd1,
    OFS_LO  = 2'd2,
    OFS_EN  = 2'd3
  } brk_ofs_e;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
  import brk_pkg::*;
#(
  parameter int NUM_ENT = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SLOT_W-1:0]                slot,
  input  brk_ofs_e                         ofs,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_ENT-1:0][CMP_W-1:0]    ent_o,
  output logic [NUM_ENT-1:0]               en_o
);
  logic [3:0] tmp_hi_q, tmp_hi_d;
  logic [7:0] tmp_mid_q, tmp_mid_d;

  always_comb begin
    tmp_hi_d  = tmp_hi_q;
    tmp_mid_d = tmp_mid_q;
    if (wr_en && ofs == OFS_HI)  tmp_hi_d  = wdata[3:0];
    if (wr_en && ofs == OFS_MID) tmp_mid_d = wdata;
  end

  always_ff @(posedge clk) begin
    tmp_hi_q  <= tmp_hi_d;
    tmp_mid_q <= tmp_mid_d;
  end

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
    logic             sel;
    logic             ld_addr, ld_en;
    logic [CMP_W-1:0] ent_q;
    logic             en_q;

    assign sel     = wr_en && (slot == SLOT_W'(n));
    assign ld_addr = sel && (ofs == OFS_LO);
    assign ld_en   = sel && (ofs == OFS_EN);

    always_ff @(posedge clk) begin
      if (ld_addr) ent_q <= {tmp_hi_q, tmp_mid_q, wdata[7:2]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (ld_en) en_q <= wdata[7];
    end

    assign ent_o[n] = ent_q;
    assign en_o[n]  = en_q;
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int NUM_ENT = 32,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0][CMP_W-1:0] ent_i,
  input  logic [NUM_ENT-1:0]            en_i,
  input  logic [CMP_W-1:0]              cmp_addr,
  input  logic                          rom_sel,
  output logic                          any_hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [NUM_ENT-1:0] hit;

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_cmp
    assign hit[n] = rom_sel && en_i[n] && (ent_i[n] == cmp_addr);
  end

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    any_hit = 1'b0;
    hit_idx = '0;
    for (int n = NUM_ENT - 1; n >= 0; n--) begin
      if (hit[n]) begin
        any_hit = 1'b1;
        hit_idx = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/brk_hold.sv
module brk_hold #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic             clr,
  output logic             pend_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             capture;

  assign capture = !pend_q && any_hit;

  always_comb begin
    pend_d = pend_q;
    idx_d  = idx_q;
    if (clr) begin
      pend_d = 1'b0;
      idx_d  = '0;
    end else if (capture) begin
      pend_d = 1'b1;
      idx_d  = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      pend_q <= pend_d;
      idx_q  <= idx_d;
    end
  end

  assign pend_o = pend_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/brk_nmi_unit.sv
module brk_nmi_unit
  import brk_pkg::*;
#(
  parameter int NUM_ENT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              rom_sel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nmi_o
);
  localparam int IDX_W = $clog2(NUM_ENT);

  logic                          in_win, rd_win, wr_win;
  logic [SLOT_W-1:0]             slot;
  brk_ofs_e                      ofs;
  logic [NUM_ENT-1:0][CMP_W-1:0] ent;
  logic [NUM_ENT-1:0]            en;
  logic                          any_hit;
  logic [IDX_W-1:0]              hit_idx;
  logic [IDX_W-1:0]              held_idx;

  assign in_win = &addr_i[ADDR_W-1:8];
  assign rd_win = rd_i && in_win;
  assign slot   = addr_i[7:2];
  assign ofs    = brk_ofs_e'(addr_i[1:0]);
  assign wr_win = wr_i && in_win && (slot < SLOT_W'(NUM_ENT));

  brk_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_win),
    .slot  (slot),
    .ofs   (ofs),
    .wdata (wdata_i),
    .ent_o (ent),
    .en_o  (en)
  );

  brk_match #(.NUM_ENT(NUM_ENT)) u_match (
    .ent_i    (ent),
    .en_i     (en),
    .cmp_addr (addr_i[19:2]),
    .rom_sel  (rom_sel_i),
    .any_hit  (any_hit),
    .hit_idx  (hit_idx)
  );

  brk_hold #(.IDX_W(IDX_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_hit (any_hit),
    .hit_idx (hit_idx),
    .clr     (rd_win),
    .pend_o  (nmi_o),
    .idx_o   (held_idx)
  );

  assign rdata_o = rd_win ? {{(DATA_W-IDX_W){1'b0}}, held_idx} : '0;
endmodule

// File: rtl/brk_nmi_chk.sv
module brk_nmi_chk #(
  parameter int NUM_ENT = 32,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [23:0]      addr_i,
  input logic             rd_i,
  input logic             rom_sel_i,
  input logic [7:0]       rdata_o,
  input logic             nmi_o,
  input logic [IDX_W-1:0] held_idx
);
  logic stat_rd;
  assign stat_rd = rd_i && (&addr_i[23:8]);

  // R8
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !stat_rd) |=> nmi_o);

  // R8
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (!nmi_o && held_idx == '0));

  // R10
  idx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !stat_rd) |=> $stable(held_idx));

  // R6
  rdata_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[7:IDX_W] == '0);

  // R5
  rom_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(rom_sel_i));
endmodule

bind brk_nmi_unit brk_nmi_chk #(.NUM_ENT(NUM_ENT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .rom_sel_i (rom_sel_i),
  .rdata_o   (rdata_o),
  .nmi_o     (nmi_o),
  .held_idx  (held_idx)
);

// File: tb/tb_brk_nmi_unit.sv
`timescale 1ns/100ps
module tb_brk_nmi_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] addr;
  logic [7:0]  wdata;
  logic        rd, wr, rom_sel;
  logic [7:0]  rdata;
  logic        nmi;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct { int exp; string req; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  brk_nmi_unit dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rom_sel_i(rom_sel),
    .rdata_o(rdata), .nmi_o(nmi)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [23:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic prog(int n, logic [7:0] hi, logic [7:0] mid, logic [7:0] lo, logic [7:0] en);
    logic [23:0] b;
    b = 24'hFFFF00 + 24'(n * 4);
    bus_wr(b + 0, hi);
    bus_wr(b + 1, mid);
    bus_wr(b + 2, lo);
    bus_wr(b + 3, en);
  endtask

  // one access, then the request level sampled one cycle later
  task automatic fetch(logic [23:0] a, logic sel, int exp_nmi, string req);
    @(negedge clk); addr = a; rom_sel = sel;
    @(negedge clk); addr = '0; rom_sel = 1'b0;
    #1 chk(req, nmi, exp_nmi);
  endtask

  // driver: queue the expected status byte, then issue the read
  task automatic stat_rd(logic [23:0] a, int exp, string req);
    exp_t e;
    e.exp = exp; e.req = req;
    sb_q.push_back(e);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = '0;
    #1 chk({req, " clear"}, nmi, 0);
  endtask

  // monitor: compare each window read with the head of the queue
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rd && (&addr[23:8])) begin
        if (sb_q.size() == 0) begin
          chk("scoreboard underrun", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.req, rdata, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; rd = 1'b0; wr = 1'b0; rom_sel = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R1 nmi in reset", nmi, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R1 nmi after reset", nmi, 0);
    fetch(24'h000000, 1'b1, 0, "R1 disabled after reset");
    stat_rd(24'hFFFFFF, 8'h00, "R1 status after reset");

    // entry 5 = A19..A2 of 0x23454; hold enable off first
    prog(5, 8'h02, 8'h34, 8'h54, 8'h00);
    fetch(24'h823457, 1'b1, 0, "R4 disabled entry");
    bus_wr(24'hFFFF17, 8'h80);
    fetch(24'h823457, 1'b0, 0, "R5 no rom select");
    fetch(24'h823457, 1'b1, 1, "R2 upper and low bits ignored");
    repeat (5) @(negedge clk);
    #1 chk("R8 held while idle", nmi, 1);
    stat_rd(24'hFFFFFF, 8'h05, "R6 index of entry 5");
    fetch(24'h823057, 1'b1, 0, "R2 A8..A15 compared");

    // R3: staged bytes do not take effect until offset 2
    bus_wr(24'hFFFF14, 8'h07);
    bus_wr(24'hFFFF15, 8'h11);
    fetch(24'h023454, 1'b1, 1, "R3 old value still live");
    stat_rd(24'hFFFFFF, 8'h05, "R3 old value index");
    fetch(24'h071100, 1'b1, 0, "R3 staged value not live");
    bus_wr(24'hFFFF16, 8'h00);
    fetch(24'h071102, 1'b1, 1, "R3 committed value live");
    stat_rd(24'hFFFFFF, 8'h05, "R3 committed index");
    fetch(24'h023454, 1'b1, 0, "R3 old value gone");

    // R7: two entries with one value
    prog(9, 8'h0A, 8'hBC, 8'hD0, 8'h80);
    prog(2, 8'h0A, 8'hBC, 8'hD0, 8'h80);
    fetch(24'h4ABCD1, 1'b1, 1, "R7 double hit");
    stat_rd(24'hFFFF00, 8'h02, "R7 lowest entry wins");
    bus_wr(24'hFFFF0B, 8'h00);
    fetch(24'h4ABCD0, 1'b1, 1, "R4 entry 9 alone");

    // R10: pending request keeps the first number
    fetch(24'h071100, 1'b1, 1, "R10 second hit while pending");
    stat_rd(24'hFFFF17, 8'h09, "R10 first index kept; R9 read at enable byte");

    // R6: highest entry number
    prog(31, 8'h0F, 8'hFF, 8'hFC, 8'h80);
    fetch(24'hCFFFFE, 1'b1, 1, "R6 entry 31 hit");
    stat_rd(24'hFFFFA3, 8'h1F, "R6 entry 31 reads 1F; R9 partial decode");
    stat_rd(24'hFFFF14, 8'h00, "R9 entry bytes not readable");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule